// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block drives the command, address, bank, clock-enable and byte-mask pins of a single-data-rate SDRAM from the moment reset is released until the memory is ready for normal traffic. It first holds the bus deselected, with CKE and every DQM line high, for a power-stable interval. That interval is a cycle count derived from a clock-frequency parameter and a microsecond parameter. It then precharges all banks and issues a parameterized number of auto-refresh commands. It also loads the mode register from a 12-bit configuration word, either before or after the refreshes, as a parameter selects. NOP cycles separate every pair of commands, and the length of each gap is a parameter.

When the last gap has run out, the block raises `init_done` and leaves the bus deselected so that a read/write controller can take it over. A low level on the asynchronous reset restarts the whole sequence from the power-stable wait. Normal accesses, periodic refresh and the data path lie outside this block.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is low, and for WAIT_CYC = CLK_MHZ*POWER_US cycles after its release, the bus is deselected (cmd_cs_n=1). During that time mem_cke=1, every mem_dqm bit is 1 and init_done=0.
- R2: The first command after the wait is a precharge-all, {cs_n,ras_n,cas_n,we_n}=0010 with address bit 10 set. It is issued in the cycle that follows the last wait cycle.
- R3: After the precharge, exactly TRP_NOP NOP cycles pass before the next command.
- R4: Exactly REF_NUM auto-refresh commands (code 0001) are issued, with REF_NUM of at least 2. Two consecutive refreshes are separated by exactly TRC_NOP NOP cycles, and the last refresh is followed by TRC_NOP NOP cycles.
- R5: The mode register load (code 0000) drives the whole configuration word onto the address. Bits [2:0] are the burst length, bit 3 is the burst type, bits [6:4] are the CAS latency and bits [11:7] are the mode options. The bank address is 0. The load is issued only after the precharge gap or a refresh gap, when all banks are idle.
- R6: After a mode register load, exactly MRD_NOP NOP cycles (at least 2) pass before any other command or the end of the sequence.
- R7: With MRS_FIRST=0 the order is precharge, refreshes, mode load. With MRS_FIRST=1 the order is precharge, mode load, refreshes.
- R8: init_done rises in the cycle after the final gap ends and stays high until reset. After that the bus is deselected.
- R9: Asserting reset in the middle of the sequence clears init_done and deselects the bus at once. After release, the full sequence runs again from the start of the wait.
- R10: Gap cycles drive a NOP, coded as cs_n=0 with ras_n, cas_n and we_n high. No command other than precharge, refresh and mode load appears at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_mode | input | ADDR_W | Mode word driven onto the address during the mode load |
| mem_cke | output | 1 | Clock enable to the memory |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| mem_dqm | output | DQM_W | Byte masks, held high |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address / op-code bus |
| init_done | output | 1 | High once initialization is complete |

## Verification
Two instances run side by side: one loads the mode register after three refreshes, and the other loads it first and refreshes twice. The comparison separates a correct order and gap count from a sequencer that ignores the order parameter or miscounts refreshes. Each logged command is compared against a cycle number computed from the gap parameters, so a gap that is off by one cycle on any edge is caught. Two different configuration words, the second one after a reset in the middle of the sequence, show that the mode load carries the live word and that a restart begins again from the power-stable wait.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PALL,
    ST_PGAP,
    ST_AREF,
    ST_RGAP,
    ST_LMR,
    ST_MGAP,
    ST_DONE
  } boot_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t CMD_PALL  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t CMD_LMR   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  function automatic logic cmd_is_quiet(input cmd_pins_t c);
    return c.cs_n | (c.ras_n & c.cas_n & c.we_n);
  endfunction

endpackage

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
  parameter int unsigned    CW      = 14,
  parameter logic [CW-1:0]  RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // R3 R4 R6: an expired gap stays expired until the sequencer reloads it
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/boot_step_fsm.sv
module boot_step_fsm
  import sdram_boot_pkg::*;
#(
  parameter int unsigned WAIT_CYC  = 12500,
  parameter int unsigned TRP_NOP   = 3,
  parameter int unsigned TRC_NOP   = 8,
  parameter int unsigned MRD_NOP   = 2,
  parameter int unsigned REF_NUM   = 2,
  parameter bit          MRS_FIRST = 1'b0,
  parameter int unsigned CW        = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output boot_st_e      st
);

  localparam int unsigned RW = $clog2(REF_NUM + 1);
  localparam boot_st_e AFTER_PGAP = MRS_FIRST ? ST_LMR  : ST_AREF;
  localparam boot_st_e AFTER_REFS = MRS_FIRST ? ST_DONE : ST_LMR;
  localparam boot_st_e AFTER_MGAP = MRS_FIRST ? ST_AREF : ST_DONE;

  boot_st_e      st_q, st_d;
  logic [RW-1:0] rc_q, rc_d;

  always_comb begin
    st_d = st_q;
    rc_d = rc_q;
    unique case (st_q)
      ST_WAIT: if (tmr_zero) st_d = ST_PALL;
      ST_PALL: st_d = ST_PGAP;
      ST_PGAP: if (tmr_zero) st_d = AFTER_PGAP;
      ST_AREF: begin
        st_d = ST_RGAP;
        rc_d = rc_q + 1'b1;
      end
      ST_RGAP: if (tmr_zero) begin
        st_d = (rc_q == RW'(REF_NUM)) ? AFTER_REFS : ST_AREF;
      end
      ST_LMR:  st_d = ST_MGAP;
      ST_MGAP: if (tmr_zero) st_d = AFTER_MGAP;
      default: st_d = ST_DONE;
    endcase
  end

  always_comb begin
    tmr_load = (st_d != st_q);
    unique case (st_d)
      ST_PGAP: tmr_val = CW'(TRP_NOP - 1);
      ST_RGAP: tmr_val = CW'(TRC_NOP - 1);
      ST_MGAP: tmr_val = CW'(MRD_NOP - 1);
      default: tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT;
      rc_q <= '0;
    end else begin
      st_q <= st_d;
      rc_q <= rc_d;
    end
  end

  assign st = st_q;

  // R2
  pall_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PALL) |-> ($past(st_q) == ST_WAIT));

  // R5
  lmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LMR) |-> ($past(st_q) == ST_PGAP || $past(st_q) == ST_RGAP));

  // R4
  ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |-> (rc_q == RW'(REF_NUM)));

endmodule

// File: rtl/boot_cmd_drive.sv
module boot_cmd_drive
  import sdram_boot_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BA_W     = 1,
  parameter int unsigned DQM_W    = 2,
  parameter int unsigned PALL_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  boot_st_e          st,
  input  logic [ADDR_W-1:0] cfg_mode,
  output logic              mem_cke,
  output cmd_pins_t         cmd,
  output logic [DQM_W-1:0]  mem_dqm,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr
);

  always_comb begin
    cmd      = CMD_DESEL;
    mem_addr = '0;
    mem_ba   = '0;
    unique case (st)
      ST_PALL: begin
        cmd                = CMD_PALL;
        mem_addr[PALL_BIT] = 1'b1;
      end
      ST_PGAP, ST_RGAP, ST_MGAP: cmd = CMD_NOP;
      ST_AREF: cmd = CMD_AREF;
      ST_LMR: begin
        cmd      = CMD_LMR;
        mem_addr = cfg_mode;
      end
      default: cmd = CMD_DESEL;
    endcase
  end

  assign mem_cke = 1'b1;
  assign mem_dqm = '1;

  logic cmd_lmr;
  assign cmd_lmr = (cmd == CMD_LMR);

  // R6
  lmr_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_lmr) |-> cmd_is_quiet(cmd));

  // R6
  lmr_gap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_lmr, 2) |-> cmd_is_quiet(cmd));

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned POWER_US  = 100,
  parameter int unsigned TRP_NOP   = 3,
  parameter int unsigned TRC_NOP   = 8,
  parameter int unsigned MRD_NOP   = 2,
  parameter int unsigned REF_NUM   = 2,
  parameter bit          MRS_FIRST = 1'b0,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 1,
  parameter int unsigned DQM_W     = 2,
  parameter int unsigned PALL_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_mode,
  output logic              mem_cke,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [DQM_W-1:0]  mem_dqm,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  localparam int unsigned WAIT_CYC = CLK_MHZ * POWER_US;
  localparam int unsigned CW = $clog2(WAIT_CYC + TRP_NOP + TRC_NOP + MRD_NOP + 1);

  logic          tmr_zero;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  boot_st_e      st;
  cmd_pins_t     cmd;

  boot_gap_timer #(
    .CW      (CW),
    .RST_VAL (CW'(WAIT_CYC - 1))
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  boot_step_fsm #(
    .WAIT_CYC  (WAIT_CYC),
    .TRP_NOP   (TRP_NOP),
    .TRC_NOP   (TRC_NOP),
    .MRD_NOP   (MRD_NOP),
    .REF_NUM   (REF_NUM),
    .MRS_FIRST (MRS_FIRST),
    .CW        (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .st       (st)
  );

  boot_cmd_drive #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .DQM_W    (DQM_W),
    .PALL_BIT (PALL_BIT)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .cfg_mode (cfg_mode),
    .mem_cke  (mem_cke),
    .cmd      (cmd),
    .mem_dqm  (mem_dqm),
    .mem_ba   (mem_ba),
    .mem_addr (mem_addr)
  );

  assign cmd_cs_n  = cmd.cs_n;
  assign cmd_ras_n = cmd.ras_n;
  assign cmd_cas_n = cmd.cas_n;
  assign cmd_we_n  = cmd.we_n;
  assign init_done = (st == ST_DONE);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cmd_cs_n);

endmodule

// File: tb/sdram_boot_seq_tb.sv
`timescale 1ns/1ps
module sdram_boot_seq_tb;

  localparam int CLK_MHZ = 125;
  localparam int PWR_US  = 1;
  localparam int W       = CLK_MHZ * PWR_US;
  localparam int TRP     = 2;
  localparam int MRD     = 2;
  localparam int TRC_A   = 6;
  localparam int N_A     = 3;
  localparam int TRC_B   = 4;
  localparam int N_B     = 2;

  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_LMR  = 4'b0000;
  localparam logic [3:0] C_DONE = 4'b1111;

  typedef struct packed {
    logic        d;
    logic [3:0]  cmd;
    logic [15:0] cyc;
  } vec_t;

  localparam int B0 = W + 1 + TRP;
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{d: 1'b0, cmd: C_PRE,  cyc: 16'(W)},
    '{d: 1'b0, cmd: C_REF,  cyc: 16'(B0)},
    '{d: 1'b0, cmd: C_REF,  cyc: 16'(B0 + (1 + TRC_A))},
    '{d: 1'b0, cmd: C_REF,  cyc: 16'(B0 + 2 * (1 + TRC_A))},
    '{d: 1'b0, cmd: C_LMR,  cyc: 16'(B0 + N_A * (1 + TRC_A))},
    '{d: 1'b0, cmd: C_DONE, cyc: 16'(B0 + N_A * (1 + TRC_A) + 1 + MRD)},
    '{d: 1'b1, cmd: C_PRE,  cyc: 16'(W)},
    '{d: 1'b1, cmd: C_LMR,  cyc: 16'(B0)},
    '{d: 1'b1, cmd: C_REF,  cyc: 16'(B0 + 1 + MRD)},
    '{d: 1'b1, cmd: C_REF,  cyc: 16'(B0 + 1 + MRD + (1 + TRC_B))},
    '{d: 1'b1, cmd: C_DONE, cyc: 16'(B0 + 1 + MRD + N_B * (1 + TRC_B))}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [11:0] cfg;

  logic        a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done;
  logic [1:0]  a_dqm;
  logic [0:0]  a_ba;
  logic [11:0] a_addr;
  logic        b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_done;
  logic [1:0]  b_dqm;
  logic [0:0]  b_ba;
  logic [11:0] b_addr;

  sdram_boot_seq #(
    .CLK_MHZ(CLK_MHZ), .POWER_US(PWR_US), .TRP_NOP(TRP), .TRC_NOP(TRC_A),
    .MRD_NOP(MRD), .REF_NUM(N_A), .MRS_FIRST(1'b0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg), .mem_cke(a_cke),
    .cmd_cs_n(a_cs_n), .cmd_ras_n(a_ras_n), .cmd_cas_n(a_cas_n), .cmd_we_n(a_we_n),
    .mem_dqm(a_dqm), .mem_ba(a_ba), .mem_addr(a_addr), .init_done(a_done)
  );

  sdram_boot_seq #(
    .CLK_MHZ(CLK_MHZ), .POWER_US(PWR_US), .TRP_NOP(TRP), .TRC_NOP(TRC_B),
    .MRD_NOP(MRD), .REF_NUM(N_B), .MRS_FIRST(1'b1)
  ) u_dut_mf (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg), .mem_cke(b_cke),
    .cmd_cs_n(b_cs_n), .cmd_ras_n(b_ras_n), .cmd_cas_n(b_cas_n), .cmd_we_n(b_we_n),
    .mem_dqm(b_dqm), .mem_ba(b_ba), .mem_addr(b_addr), .init_done(b_done)
  );

  int total = 0;
  int bad   = 0;
  int cyc;
  int wait_viol;
  int ln   [2];
  int dcyc [2];
  logic [3:0]  lcmd  [2][16];
  int          lcyc  [2][16];
  logic [11:0] laddr [2][16];
  logic        lba   [2][16];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic log_one(input int d, input logic [3:0] c, input logic [11:0] ad, input logic b);
    if (!c[3] && c != 4'b0111 && ln[d] < 16) begin
      lcmd[d][ln[d]]  = c;
      lcyc[d][ln[d]]  = cyc;
      laddr[d][ln[d]] = ad;
      lba[d][ln[d]]   = b;
      ln[d]++;
    end
  endtask

  task automatic clear_logs();
    for (int d = 0; d < 2; d++) begin
      ln[d]   = 0;
      dcyc[d] = -1;
    end
    wait_viol = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      log_one(0, {a_cs_n, a_ras_n, a_cas_n, a_we_n}, a_addr, a_ba[0]);
      log_one(1, {b_cs_n, b_ras_n, b_cas_n, b_we_n}, b_addr, b_ba[0]);
      if (a_done && dcyc[0] < 0) dcyc[0] = cyc;
      if (b_done && dcyc[1] < 0) dcyc[1] = cyc;
      if (cyc < W && (!a_cs_n || !b_cs_n || !a_cke || !b_cke ||
                      a_dqm != 2'b11 || b_dqm != 2'b11 || a_done || b_done))
        wait_viol++;
    end
  end

  task automatic wait_both();
    for (int i = 0; i < 1000; i++) begin
      if (dcyc[0] >= 0 && dcyc[1] >= 0) break;
      @(negedge clk);
    end
    if (dcyc[0] < 0 || dcyc[1] < 0)
      chk(1'b0, "R8 sequence did not finish", dcyc[0], 0);
  endtask

  function automatic string tag_of(input logic d, input logic [3:0] c);
    if (d) return "R7";
    case (c)
      C_PRE:   return "R2";
      C_REF:   return "R4";
      C_LMR:   return "R5";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k [2];
    rst_n = 1'b0;
    cfg   = 12'h0A3;
    clear_logs();
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(a_cs_n == 1'b1 && b_cs_n == 1'b1, "R1 deselect in reset", a_cs_n, 1);
    chk(a_cke == 1'b1 && a_dqm == 2'b11, "R1 cke/dqm high in reset", {a_cke, a_dqm}, 7);
    chk(a_done == 1'b0 && b_done == 1'b0, "R1 init_done low in reset", a_done, 0);

    rst_n = 1'b1;
    wait_both();

    // R1: quiet wait window
    chk(wait_viol == 0, "R1 wait window quiet", wait_viol, 0);

    // R7 R2 R4 R5 R8 R10: expected command codes and cycles, one loop
    k[0] = 0;
    k[1] = 0;
    for (int i = 0; i < NV; i++) begin
      int d;
      d = int'(VEC[i].d);
      if (VEC[i].cmd == C_DONE) begin
        chk(dcyc[d] == int'(VEC[i].cyc), tag_of(VEC[i].d, C_DONE), dcyc[d], int'(VEC[i].cyc));
      end else begin
        chk(lcmd[d][k[d]] == VEC[i].cmd, {tag_of(VEC[i].d, VEC[i].cmd), " R10 code"},
            int'(lcmd[d][k[d]]), int'(VEC[i].cmd));
        chk(lcyc[d][k[d]] == int'(VEC[i].cyc), {tag_of(VEC[i].d, VEC[i].cmd), " cycle"},
            lcyc[d][k[d]], int'(VEC[i].cyc));
        k[d]++;
      end
    end

    // R4 R10: nothing beyond the expected commands
    chk(ln[0] == N_A + 2, "R4 R10 command count order A", ln[0], N_A + 2);
    chk(ln[1] == N_B + 2, "R4 R10 command count order B", ln[1], N_B + 2);
    // R2
    chk(laddr[0][0][10] == 1'b1, "R2 precharge-all bit", int'(laddr[0][0][10]), 1);
    // R3
    chk(lcyc[0][1] - lcyc[0][0] - 1 == TRP, "R3 precharge gap", lcyc[0][1] - lcyc[0][0] - 1, TRP);
    // R5
    chk(laddr[0][N_A + 1] == cfg, "R5 mode word order A", int'(laddr[0][N_A + 1]), int'(cfg));
    chk(laddr[1][1] == cfg && lba[1][1] == 1'b0, "R5 mode word order B", int'(laddr[1][1]), int'(cfg));
    // R6
    chk(lcyc[1][2] - lcyc[1][1] - 1 == MRD, "R6 gap after mode load", lcyc[1][2] - lcyc[1][1] - 1, MRD);

    // R8: stays done and quiet
    repeat (20) @(negedge clk);
    chk(a_done && b_done, "R8 init_done held", {a_done, b_done}, 3);
    chk(a_cs_n && b_cs_n, "R8 bus deselected after done", {a_cs_n, b_cs_n}, 3);

    // R9: reset in the middle of the sequence
    @(negedge clk);
    rst_n = 1'b0;
    cfg   = 12'hF38;
    @(negedge clk);
    rst_n = 1'b1;
    clear_logs();
    repeat (131) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!a_done && a_cs_n && b_cs_n, "R9 mid-run reset deselects", {a_done, a_cs_n, b_cs_n}, 3);
    @(negedge clk);
    clear_logs();
    rst_n = 1'b1;
    wait_both();
    chk(lcmd[0][0] == C_PRE && lcyc[0][0] == W, "R9 restart precharge cycle", lcyc[0][0], W);
    chk(dcyc[0] == int'(VEC[5].cyc), "R9 restart done cycle", dcyc[0], int'(VEC[5].cyc));
    chk(laddr[0][N_A + 1] == cfg, "R9 R5 new mode word", int'(laddr[0][N_A + 1]), int'(cfg));
    chk(wait_viol == 0, "R9 R1 wait repeated", wait_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule